// File: doc/BRIEF.md
# Exception Entry and Return Status Controller

This block computes the status-side effects of taking an exception in a small 32-bit RISC core. Each cycle it looks at the current status word, the return address and seven exception request lines. It masks the two interrupt requests with the status-word disable bits and picks one winner by fixed priority. In the same cycle, with no register on the path, it presents the values the core writes: the banked link register of the target mode, the saved copy of the status word, the new status word and the new program counter.

The block keeps one saved status register for each of the five privileged exception modes (fast interrupt, interrupt, supervisor, abort, undefined). When a request is taken, the incoming status word is stored in the slot of the target mode at the next rising clock edge. An exception-return pulse reads the slot that belongs to the mode in the current status word and offers it as the next status word. User and system mode own no slot.

All pins are plain control and data levels sampled every cycle. Nothing flows as a stream, so there is no valid/ready pair and no back-pressure. The core must write the presented values in the same cycle that the enable is high.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When at least one request survives masking, `pc_we`, `lr_we` and `psr_we` are all 1 in that same cycle. When no request survives and `exc_return` is 0, all three are 0 and `psr_next` equals `cur_psr`.
- R2: On entry, `lr_data` equals `ret_addr`, `spsr_wdata` equals `cur_psr`, and `lr_mode` equals the target mode code.
- R3: On entry, `psr_next[4:0]` is the target mode code and `psr_next[31:8]` equals `cur_psr[31:8]`. The codes are: fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011. Reset and software interrupt enter supervisor mode. Prefetch and data abort enter abort mode.
- R4: On entry, `psr_next[5]` (instruction-set state) is 0 and `psr_next[7]` (interrupt disable) is 1.
- R5: On entry, `psr_next[6]` (fast-interrupt disable) is 1 when the winner is reset or fast interrupt. Otherwise it equals `cur_psr[6]`.
- R6: On entry, `pc_next` is the vector of the winner: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C.
- R7: The winner is chosen in this order, highest first: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R8: `req_irq` is ignored while `cur_psr[7]` is 1. `req_fiq` is ignored while `cur_psr[6]` is 1.
- R9: With `exc_return` at 1, no entry taken, and `cur_psr[4:0]` naming one of the five exception modes, `psr_we` is 1 and `psr_next` equals the status word that was saved on the most recent entry into that mode.
- R10: With `exc_return` at 1, no entry taken, and `cur_psr[4:0]` being user (10000), system (11111) or any other code, `psr_we` is 0 and `psr_next` equals `cur_psr`.
- R11: When an entry and `exc_return` fall in the same cycle, the entry alone takes effect, and its saved-status write still happens.
- R12: While `rst_n` is 0, all saved status registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; saved-status writes occur on the rising edge |
| rst_n | input | 1 | Active-low reset; clears saved status registers |
| cur_psr | input | 32 | Current status word |
| ret_addr | input | 32 | Return address for the link register |
| req_reset | input | 1 | Reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| exc_return | input | 1 | Exception return: restore status from saved register |
| pc_we | output | 1 | Program counter write enable |
| pc_next | output | 32 | Vector address to load |
| psr_we | output | 1 | Status word write enable |
| psr_next | output | 32 | Next status word |
| lr_we | output | 1 | Banked link register write enable |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | 32 | Link register write value |
| spsr_wdata | output | 32 | Value stored into the target mode's saved status register |

## Verification
Exception entry and exception return can both be requested in the same cycle, and both want to drive the status word. The bench drives an unmasked interrupt request together with a return pulse while the status word names interrupt mode. It expects the entry values on every output. It then issues a lone return in interrupt mode to confirm that the saved slot now holds the status word seen in that shared cycle and not an older value.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int MODE_W   = 5;
  localparam int NUM_REQ  = 7;
  localparam int NUM_BANK = 5;
  localparam int SLOT_W   = $clog2(NUM_BANK);

  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Enumeration order follows arbitration priority (index + 1).
  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_RESET = 3'd1,
    EXC_DABT  = 3'd2,
    EXC_FIQ   = 3'd3,
    EXC_IRQ   = 3'd4,
    EXC_PABT  = 3'd5,
    EXC_UNDEF = 3'd6,
    EXC_SWI   = 3'd7
  } exc_e;

  function automatic logic [MODE_W-1:0] target_mode(exc_e k);
    case (k)
      EXC_RESET, EXC_SWI: return MODE_SVC;
      EXC_DABT, EXC_PABT: return MODE_ABT;
      EXC_FIQ:            return MODE_FIQ;
      EXC_IRQ:            return MODE_IRQ;
      EXC_UNDEF:          return MODE_UND;
      default:            return MODE_USR;
    endcase
  endfunction

  function automatic logic [7:0] vector_offset(exc_e k);
    case (k)
      EXC_UNDEF: return 8'h04;
      EXC_SWI:   return 8'h08;
      EXC_PABT:  return 8'h0C;
      EXC_DABT:  return 8'h10;
      EXC_IRQ:   return 8'h18;
      EXC_FIQ:   return 8'h1C;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic logic has_bank(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] bank_slot(logic [MODE_W-1:0] m);
    case (m)
      MODE_IRQ: return SLOT_W'(1);
      MODE_SVC: return SLOT_W'(2);
      MODE_ABT: return SLOT_W'(3);
      MODE_UND: return SLOT_W'(4);
      default:  return SLOT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NUM_REQ = 7
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant,
  output logic               any
);
  // Index 0 has the highest priority.
  logic [NUM_REQ:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
    assign grant[g]     = req[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req[g];
  end

  assign any = blocked[NUM_REQ];
endmodule

// File: rtl/exc_psr_calc.sv
module exc_psr_calc
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  exc_e              kind,
  input  logic [DATA_W-1:0] cur_psr,
  output logic [DATA_W-1:0] psr_new,
  output logic [DATA_W-1:0] pc_new,
  output logic [MODE_W-1:0] mode_new
);
  always_comb begin
    mode_new          = target_mode(kind);
    pc_new            = DATA_W'(vector_offset(kind));
    psr_new           = cur_psr;
    psr_new[MODE_W-1:0] = mode_new;
    psr_new[PSR_T]    = 1'b0;
    psr_new[PSR_I]    = 1'b1;
    if (kind == EXC_RESET || kind == EXC_FIQ) psr_new[PSR_F] = 1'b1;
  end
endmodule

// File: rtl/exc_spsr_bank.sv
module exc_spsr_bank
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit
);
  logic [DATA_W-1:0] slot_q [NUM_BANK];
  logic              wr_ok;
  logic [SLOT_W-1:0] wr_slot;

  assign wr_ok   = wr_en & has_bank(wr_mode);
  assign wr_slot = bank_slot(wr_mode);

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_ok && wr_slot == SLOT_W'(g))
        slot_q[g] <= wr_data;
    end
  end

  assign rd_hit  = has_bank(rd_mode);
  assign rd_data = slot_q[bank_slot(rd_mode)];
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cur_psr,
  input  logic [DATA_W-1:0] ret_addr,
  input  logic              req_reset,
  input  logic              req_dabort,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabort,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              exc_return,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_next,
  output logic              psr_we,
  output logic [DATA_W-1:0] psr_next,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [DATA_W-1:0] lr_data,
  output logic [DATA_W-1:0] spsr_wdata
);
  logic [NUM_REQ-1:0] req_eff;
  logic [NUM_REQ-1:0] grant;
  logic               take;
  exc_e               kind;
  logic [DATA_W-1:0]  psr_entry;
  logic [DATA_W-1:0]  pc_entry;
  logic [MODE_W-1:0]  mode_entry;
  logic [DATA_W-1:0]  saved_psr;
  logic               saved_hit;
  logic               restore;

  // Priority order, index 0 first; interrupt lines gated by disable bits (R8).
  assign req_eff = {req_swi, req_undef, req_pabort,
                    req_irq & ~cur_psr[PSR_I],
                    req_fiq & ~cur_psr[PSR_F],
                    req_dabort, req_reset};

  exc_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
    .req   (req_eff),
    .grant (grant),
    .any   (take)
  );

  always_comb begin
    kind = EXC_NONE;
    for (int i = NUM_REQ - 1; i >= 0; i--)
      if (grant[i]) kind = exc_e'(3'(i + 1));
  end

  exc_psr_calc #(.DATA_W(DATA_W)) u_calc (
    .kind     (kind),
    .cur_psr  (cur_psr),
    .psr_new  (psr_entry),
    .pc_new   (pc_entry),
    .mode_new (mode_entry)
  );

  exc_spsr_bank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take),
    .wr_mode (mode_entry),
    .wr_data (cur_psr),
    .rd_mode (cur_psr[MODE_W-1:0]),
    .rd_data (saved_psr),
    .rd_hit  (saved_hit)
  );

  // Entry has precedence over return (R11).
  assign restore = exc_return & saved_hit & ~take;

  always_comb begin
    pc_we      = take;
    lr_we      = take;
    psr_we     = take | restore;
    pc_next    = pc_entry;
    lr_mode    = mode_entry;
    lr_data    = ret_addr;
    spsr_wdata = cur_psr;
    if (take)         psr_next = psr_entry;
    else if (restore) psr_next = saved_psr;
    else              psr_next = cur_psr;
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cur_psr,
  input logic [DATA_W-1:0] ret_addr,
  input logic              req_reset,
  input logic              req_dabort,
  input logic              req_fiq,
  input logic              req_irq,
  input logic              req_pabort,
  input logic              req_undef,
  input logic              req_swi,
  input logic              exc_return,
  input logic              pc_we,
  input logic [DATA_W-1:0] pc_next,
  input logic              psr_we,
  input logic [DATA_W-1:0] psr_next,
  input logic              lr_we,
  input logic [MODE_W-1:0] lr_mode,
  input logic [DATA_W-1:0] lr_data,
  input logic [DATA_W-1:0] spsr_wdata
);
  logic others_idle;
  assign others_idle = !req_reset && !req_dabort && !req_fiq && !req_pabort
                       && !req_undef && !req_swi;

  p_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (lr_we && psr_we));

  p_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (lr_data == ret_addr && spsr_wdata == cur_psr
               && lr_mode == psr_next[MODE_W-1:0]));

  p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (psr_next[DATA_W-1:8] == cur_psr[DATA_W-1:8]));

  p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (!psr_next[PSR_T] && psr_next[PSR_I]));

  p_fmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && psr_next[MODE_W-1:0] != MODE_FIQ && pc_next != '0)
      |-> (psr_next[PSR_F] == cur_psr[PSR_F]));

  p_fiq_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fiq && !cur_psr[PSR_F] && !req_reset && !req_dabort)
      |-> (pc_we && pc_next == DATA_W'(8'h1C)));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && cur_psr[PSR_I] && others_idle) |-> !pc_we);

  p_no_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && (cur_psr[MODE_W-1:0] == MODE_USR || cur_psr[MODE_W-1:0] == MODE_SYS))
      |-> (!psr_we && psr_next == cur_psr));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_psr, ret_addr;
  logic [6:0]  rq;   // 0 reset,1 dabort,2 fiq,3 irq,4 pabort,5 undef,6 swi
  logic        exc_return;
  logic        pc_we, psr_we, lr_we;
  logic [31:0] pc_next, psr_next, lr_data, spsr_wdata;
  logic [4:0]  lr_mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .cur_psr(cur_psr), .ret_addr(ret_addr),
    .req_reset(rq[0]), .req_dabort(rq[1]), .req_fiq(rq[2]), .req_irq(rq[3]),
    .req_pabort(rq[4]), .req_undef(rq[5]), .req_swi(rq[6]),
    .exc_return(exc_return),
    .pc_we(pc_we), .pc_next(pc_next), .psr_we(psr_we), .psr_next(psr_next),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data), .spsr_wdata(spsr_wdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [135:0] got, input logic [135:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Expected entry outputs from the requirement text.
  function automatic logic [135:0] model(input logic [6:0] r, input logic [31:0] psr,
                                          input logic [31:0] ra);
    logic [6:0]  eff;
    int          w;
    logic [4:0]  m;
    logic [31:0] v, np;
    eff = r;
    eff[3] = r[3] & ~psr[7];
    eff[2] = r[2] & ~psr[6];
    w = -1;
    for (int i = 0; i < 7; i++) if (eff[i] && w < 0) w = i;
    case (w)
      0: begin m = 5'b10011; v = 32'h00; end
      1: begin m = 5'b10111; v = 32'h10; end
      2: begin m = 5'b10001; v = 32'h1C; end
      3: begin m = 5'b10010; v = 32'h18; end
      4: begin m = 5'b10111; v = 32'h0C; end
      5: begin m = 5'b11011; v = 32'h04; end
      6: begin m = 5'b10011; v = 32'h08; end
      default: begin m = 5'b00000; v = 32'h0; end
    endcase
    if (w < 0) return {3'b000, 32'h0, psr, 5'h0, 64'h0};
    np = psr;
    np[4:0] = m;
    np[5] = 1'b0;
    np[7] = 1'b1;
    if (w == 0 || w == 2) np[6] = 1'b1;
    return {3'b111, v, np, m, ra, psr};
  endfunction

  function automatic logic [135:0] observed();
    return {pc_we, lr_we, psr_we, pc_next, psr_next, lr_mode, lr_data, spsr_wdata};
  endfunction

  task automatic drive(input logic [6:0] r, input logic [31:0] psr,
                       input logic [31:0] ra, input logic rtn);
    @(negedge clk);
    rq = r; cur_psr = psr; ret_addr = ra; exc_return = rtn;
    #1;
  endtask

  task automatic check_return(input logic [31:0] psr, input logic we_exp,
                              input logic [31:0] exp, input string tag);
    drive(7'h00, psr, 32'h0, 1'b1);
    check({pc_we, psr_we, psr_next} == {1'b0, we_exp, exp}, tag,
          136'({pc_we, psr_we, psr_next}), 136'({1'b0, we_exp, exp}));
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [135:0] exp, msk, got;
    logic [31:0]  saved [5];
    logic [4:0]   modes [5];
    logic [6:0]   enter [5];
    rst_n = 1'b0; rq = '0; cur_psr = '0; ret_addr = '0; exc_return = 1'b0;
    modes[0] = 5'b10001; enter[0] = 7'b0000100;
    modes[1] = 5'b10010; enter[1] = 7'b0001000;
    modes[2] = 5'b10011; enter[2] = 7'b1000000;
    modes[3] = 5'b10111; enter[3] = 7'b0010000;
    modes[4] = 5'b11011; enter[4] = 7'b0100000;
    repeat (3) @(posedge clk);
    #1;
    // R12: saved registers read as zero during reset.
    cur_psr = 32'h0000_0012; exc_return = 1'b1;
    #1;
    check(psr_next == 32'h0 && !pc_we, "R12 reset slot", 136'(psr_next), 136'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R12 after reset release: every exception mode's slot is zero.
    for (int k = 0; k < 5; k++)
      check_return({27'h0, modes[k]}, 1'b1, 32'h0, "R12 cleared slot");

    // R1 R2 R3 R4 R5 R6 R7 R8: sweep all request sets against mask flags.
    for (int f = 0; f < 4; f++) begin
      for (int r = 0; r < 128; r++) begin
        logic [31:0] psr, ra;
        psr = {24'(r * 40503 + f * 977), f[1], f[0], 1'b1, 5'b10000};
        ra  = 32'h8000_0000 + 32'(r * 4 + f);
        drive(7'(r), psr, ra, 1'b0);
        exp = model(7'(r), psr, ra);
        msk = exp[135] ? {136{1'b1}} : {3'b111, 32'h0, 32'hFFFF_FFFF, 5'h0, 64'h0};
        got = observed();
        check((got & msk) == (exp & msk), "R1 R2 R3 R4 R5 R6 R7 R8 entry sweep", got, exp);
      end
    end

    // R9: enter each mode, then return from it.
    for (int k = 0; k < 5; k++) begin
      saved[k] = {8'h5A, 8'(k * 17), 8'h3C, 3'b001, 5'b10000};
      drive(enter[k], saved[k], 32'h4000 + 32'(k), 1'b0);
    end
    for (int k = 0; k < 5; k++)
      check_return({24'hFFFF00, 3'b110, modes[k]}, 1'b1, saved[k], "R9 restore");

    // R10: user, system and an unknown code leave status untouched.
    check_return(32'h1234_5610, 1'b0, 32'h1234_5610, "R10 user return");
    check_return(32'h1234_561F, 1'b0, 32'h1234_561F, "R10 system return");
    check_return(32'h1234_5605, 1'b0, 32'h1234_5605, "R10 unknown mode return");

    // R11: interrupt entry and return in the same cycle; entry wins.
    drive(7'b0001000, 32'hC0DE_0012, 32'h0000_BEEC, 1'b1);
    exp = model(7'b0001000, 32'hC0DE_0012, 32'h0000_BEEC);
    got = observed();
    check(got == exp, "R11 entry beats return", got, exp);
    check_return(32'h0000_0092, 1'b1, 32'hC0DE_0012, "R11 slot written in shared cycle");

    // R8: masked interrupt with return pending acts as a pure return.
    drive(7'b0001000, 32'h0000_0092, 32'h0, 1'b1);
    check({pc_we, psr_next} == {1'b0, 32'hC0DE_0012}, "R8 masked irq with return",
          136'({pc_we, psr_next}), 136'({1'b0, 32'hC0DE_0012}));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule